// File: doc/BRIEF.md
# Tagged Memory Fill Engine

This engine fills a run of memory with one byte value copied into every byte. For every 16-byte granule it fills, it also stores a 4-bit allocation tag in a separate tag memory. A request carries the current address register value, the current size register value, the fill byte, an encoding select and a per-step byte budget. The engine splits the work into blocks and issues each block to a data-write port. After a block is fully acknowledged, it writes one tag per granule of that block. When the step ends, it returns the updated address and size values, together with fault flags.

There are two register encodings. With the count-down-from-start encoding (select = 1), the address is the next byte to fill and the size is the positive number of bytes still to fill. With the count-up-to-end encoding (select = 0), the address is the end of the region and the size is the negated remaining count. In that case each block starts at address plus size.

A step is either intermediate (bounded by the budget) or final. A final step finishes everything that remains. A short acknowledge from the data port stands in for a memory fault.

Top module: `tagFillEngine`

## Requirements
- R1: Each data-write request carries the latched fill byte on `wrFill`. Its length `wrLen` is a non-zero multiple of 16, at most `BLOCK_BYTES`, and at most the bytes left in the step. `wrAddr`, `wrLen` and `wrFill` stay stable until `wrAck`.
- R2: After a block is fully acknowledged, exactly `wrLen/16` tag writes follow. All of them carry bits [59:56] of the block's start address.
- R3: Tag writes go out on consecutive cycles, from the block's highest granule address (start + len − 16) down to its start, one granule (16) lower each cycle.
- R4: With select = 1, each completed block advances the returned address by its length and lowers the returned size by its length.
- R5: With select = 0, each block starts at address + size. Each completed block raises the size by its length and leaves the address unchanged. A size whose sign bit is clear counts as zero bytes.
- R6: In an intermediate step, the bytes filled equal min(remaining, budget), rounded down to a multiple of 16.
- R7: In a final step, the whole remaining count is filled regardless of the budget, and the returned size is 0 when no fault occurred.
- R8: When `wrAckLen` differs from `wrLen`, the engine writes no tags for that block, issues no further writes and sets `fault`. The returned registers reflect only completed blocks, and the size is not zeroed even in a final step.
- R9: A size with bits [3:0] non-zero, or a non-zero size with address bits [3:0] non-zero, sets both `fault` and `alignFault`. No write is issued and the registers are returned unchanged.
- R10: `busy` is high from the cycle after an accepted `start` through the `done` cycle. `done` is high for exactly one cycle. No write of either kind happens while not busy, and `start` is ignored while busy.
- R11: A zero-byte step (zero size, or a budget below 16) completes with no writes and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a step (accepted when idle) |
| encSelB | input | 1 | 1: positive count from start address; 0: negated count from end address |
| finalStep | input | 1 | Step fills all that remains |
| addrIn | input | ADDR_W | Address register value |
| sizeIn | input | ADDR_W | Size register value |
| fillByte | input | 8 | Byte copied into every filled byte |
| stageLimit | input | ADDR_W | Byte budget for an intermediate step |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| addrOut | output | ADDR_W | Updated address register value |
| sizeOut | output | ADDR_W | Updated size register value |
| fault | output | 1 | Step ended by a fault |
| alignFault | output | 1 | Fault was a misalignment |
| wrValid | output | 1 | Data block write request |
| wrAddr | output | ADDR_W | Block start address |
| wrLen | output | LEN_W | Block length in bytes |
| wrFill | output | 8 | Fill byte for the block |
| wrAck | input | 1 | Block write finished |
| wrAckLen | input | LEN_W | Bytes actually written |
| tagValid | output | 1 | Tag write strobe |
| tagAddr | output | ADDR_W | Granule address of the tag |
| tagValue | output | 4 | Allocation tag |

## Verification
The in-RTL assertions check, on every cycle, the rules that are local in time: block length bounds and request stability while waiting for an acknowledge (R1), tag value constancy and strict downward stepping of tag addresses (R2, R3), the one-cycle `done` pulse (R10), and that a short acknowledge leads straight to completion with no tag write (R8). Only the bench scenarios can show the results that depend on arithmetic over a whole step. These are the returned address and size under both encodings, rounding and clipping of the budget, zeroing after a final step, the per-block tag count against the acknowledged length, the alignment rules, and the fact that a start pulse during a step leaves the result untouched.

// File: rtl/tfePkg.sv
package tfePkg;
  typedef struct packed {
    logic load;
    logic alignErr;
    logic pickBlk;
    logic tagStep;
    logic advance;
    logic shortErr;
    logic zeroSize;
  } tfeCtrlT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_WRITE,
    ST_TAG,
    ST_FIN
  } tfeStateT;
endpackage

// File: rtl/tfeDatapath.sv
module tfeDatapath
  import tfePkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int BLOCK_BYTES = 64,
  parameter int TAG_LSB     = 56,
  localparam int LEN_W      = $clog2(BLOCK_BYTES) + 1,
  localparam int NGRAN      = BLOCK_BYTES / 16,
  localparam int IDX_W      = $clog2(NGRAN) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tfeCtrlT           ctrl,
  input  logic              encSelB,
  input  logic              finalStep,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] sizeIn,
  input  logic [7:0]        fillByte,
  input  logic [ADDR_W-1:0] stageLimit,
  input  logic              wrValid,
  input  logic              wrAck,
  input  logic [LEN_W-1:0]  wrAckLen,
  input  logic              tagValid,
  output logic              alignBad,
  output logic              stageEmpty,
  output logic              lastGran,
  output logic              ackShort,
  output logic              finalFlag,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] sizeOut,
  output logic              fault,
  output logic              alignFault,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LEN_W-1:0]  wrLen,
  output logic [7:0]        wrFill,
  output logic [ADDR_W-1:0] tagAddr,
  output logic [3:0]        tagValue
);
  localparam int GRAN_LSB = 4;

  logic [ADDR_W-1:0] addrReg, sizeReg, stageLeft, blkStart;
  logic [7:0]        fillReg;
  logic              optBReg, finalReg, faultReg, alignReg;
  logic [LEN_W-1:0]  blkLen;
  logic [IDX_W-1:0]  granIdx;

  logic [ADDR_W-1:0] remIn, limSel, blkExt;
  logic [LEN_W-1:0]  blkNext;
  logic [IDX_W-1:0]  granNext;

  always_comb begin
    if (encSelB) remIn = sizeIn;
    else if (sizeIn[ADDR_W-1]) remIn = -sizeIn;
    else remIn = '0;
    if (finalStep) limSel = remIn;
    else limSel = (remIn < stageLimit) ? remIn : stageLimit;
  end

  assign alignBad = (sizeIn[GRAN_LSB-1:0] != '0) ||
                    ((sizeIn != '0) && (addrIn[GRAN_LSB-1:0] != '0));

  assign blkNext  = (stageLeft < ADDR_W'(BLOCK_BYTES)) ? stageLeft[LEN_W-1:0]
                                                       : LEN_W'(BLOCK_BYTES);
  assign granNext = IDX_W'((blkNext >> GRAN_LSB) - LEN_W'(1));
  assign blkExt   = {{(ADDR_W-LEN_W){1'b0}}, blkLen};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      sizeReg   <= '0;
      stageLeft <= '0;
      blkStart  <= '0;
      fillReg   <= '0;
      optBReg   <= 1'b0;
      finalReg  <= 1'b0;
      faultReg  <= 1'b0;
      alignReg  <= 1'b0;
      blkLen    <= '0;
      granIdx   <= '0;
    end else begin
      if (ctrl.load) begin
        addrReg   <= addrIn;
        sizeReg   <= sizeIn;
        fillReg   <= fillByte;
        optBReg   <= encSelB;
        finalReg  <= finalStep;
        stageLeft <= {limSel[ADDR_W-1:GRAN_LSB], {GRAN_LSB{1'b0}}};
        faultReg  <= 1'b0;
        alignReg  <= 1'b0;
      end
      if (ctrl.alignErr) begin
        faultReg <= 1'b1;
        alignReg <= 1'b1;
      end
      if (ctrl.pickBlk) begin
        blkLen   <= blkNext;
        granIdx  <= granNext;
        blkStart <= optBReg ? addrReg : addrReg + sizeReg;
      end
      if (ctrl.tagStep) granIdx <= granIdx - IDX_W'(1);
      if (ctrl.advance) begin
        stageLeft <= stageLeft - blkExt;
        if (optBReg) begin
          addrReg <= addrReg + blkExt;
          sizeReg <= sizeReg - blkExt;
        end else begin
          sizeReg <= sizeReg + blkExt;
        end
      end
      if (ctrl.shortErr) faultReg <= 1'b1;
      if (ctrl.zeroSize) sizeReg <= '0;
    end
  end

  assign stageEmpty = (stageLeft == '0);
  assign lastGran   = (granIdx == '0);
  assign ackShort   = (wrAckLen != blkLen);
  assign finalFlag  = finalReg;
  assign addrOut    = addrReg;
  assign sizeOut    = sizeReg;
  assign fault      = faultReg;
  assign alignFault = alignReg;
  assign wrAddr     = blkStart;
  assign wrLen      = blkLen;
  assign wrFill     = fillReg;
  assign tagAddr    = blkStart + ({{(ADDR_W-IDX_W){1'b0}}, granIdx} << GRAN_LSB);
  assign tagValue   = blkStart[TAG_LSB +: 4];

  // R1: block length is a non-zero granule multiple within the block limit
  assert_blk_bounds_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> (wrLen != '0) && (wrLen[GRAN_LSB-1:0] == '0) &&
                (wrLen <= LEN_W'(BLOCK_BYTES)));
  assert_wr_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrAck |=> wrValid && $stable(wrAddr) && $stable(wrLen) && $stable(wrFill));
  assert_tag_same_R2: assert property (@(posedge clk) disable iff (!rstN)
    tagValid && $past(tagValid) |-> $stable(tagValue));
  assert_tag_descend_R3: assert property (@(posedge clk) disable iff (!rstN)
    tagValid && $past(tagValid) |-> tagAddr == $past(tagAddr) - ADDR_W'(16));
endmodule

// File: rtl/tfeControl.sv
module tfeControl
  import tfePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    alignBad,
  input  logic    stageEmpty,
  input  logic    lastGran,
  input  logic    ackShort,
  input  logic    finalFlag,
  input  logic    wrAck,
  output tfeCtrlT ctrl,
  output logic    busy,
  output logic    done,
  output logic    wrValid,
  output logic    tagValid
);
  tfeStateT state, nextState;

  always_comb begin
    ctrl      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        ctrl.load = 1'b1;
        if (alignBad) begin
          ctrl.alignErr = 1'b1;
          nextState     = ST_FIN;
        end else begin
          nextState = ST_PICK;
        end
      end
      ST_PICK: if (stageEmpty) begin
        ctrl.zeroSize = finalFlag;
        nextState     = ST_FIN;
      end else begin
        ctrl.pickBlk = 1'b1;
        nextState    = ST_WRITE;
      end
      ST_WRITE: if (wrAck) begin
        if (ackShort) begin
          ctrl.shortErr = 1'b1;
          nextState     = ST_FIN;
        end else begin
          nextState = ST_TAG;
        end
      end
      ST_TAG: begin
        ctrl.tagStep = 1'b1;
        if (lastGran) begin
          ctrl.advance = 1'b1;
          nextState    = ST_PICK;
        end
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign wrValid  = (state == ST_WRITE);
  assign tagValid = (state == ST_TAG);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);
endmodule

// File: rtl/tagFillEngine.sv
module tagFillEngine
  import tfePkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int BLOCK_BYTES = 64,
  parameter int TAG_LSB     = 56,
  localparam int LEN_W      = $clog2(BLOCK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              encSelB,
  input  logic              finalStep,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] sizeIn,
  input  logic [7:0]        fillByte,
  input  logic [ADDR_W-1:0] stageLimit,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] addrOut,
  output logic [ADDR_W-1:0] sizeOut,
  output logic              fault,
  output logic              alignFault,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LEN_W-1:0]  wrLen,
  output logic [7:0]        wrFill,
  input  logic              wrAck,
  input  logic [LEN_W-1:0]  wrAckLen,
  output logic              tagValid,
  output logic [ADDR_W-1:0] tagAddr,
  output logic [3:0]        tagValue
);
  tfeCtrlT ctrl;
  logic alignBad, stageEmpty, lastGran, ackShort, finalFlag;

  tfeControl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .alignBad(alignBad),
    .stageEmpty(stageEmpty), .lastGran(lastGran), .ackShort(ackShort),
    .finalFlag(finalFlag), .wrAck(wrAck), .ctrl(ctrl), .busy(busy),
    .done(done), .wrValid(wrValid), .tagValid(tagValid)
  );

  tfeDatapath #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES), .TAG_LSB(TAG_LSB)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .encSelB(encSelB), .finalStep(finalStep),
    .addrIn(addrIn), .sizeIn(sizeIn), .fillByte(fillByte), .stageLimit(stageLimit),
    .wrValid(wrValid), .wrAck(wrAck), .wrAckLen(wrAckLen), .tagValid(tagValid),
    .alignBad(alignBad), .stageEmpty(stageEmpty), .lastGran(lastGran),
    .ackShort(ackShort), .finalFlag(finalFlag), .addrOut(addrOut), .sizeOut(sizeOut),
    .fault(fault), .alignFault(alignFault), .wrAddr(wrAddr), .wrLen(wrLen),
    .wrFill(wrFill), .tagAddr(tagAddr), .tagValue(tagValue)
  );

  // R8: a short acknowledge ends the step at once with no tag write
  assert_short_stop_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrAck && (wrAckLen != wrLen) |=> done && fault && !tagValid);
endmodule

// File: tb/tagFillEngine_test.sv
`timescale 1ns/1ps
module tagFillEngine_test;
  localparam int LEN_W = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, encSelB = 1'b0, finalStep = 1'b0;
  logic [63:0] addrIn = '0, sizeIn = '0, stageLimit = '0;
  logic [7:0] fillByte = '0;
  logic busy, done, fault, alignFault, wrValid, tagValid;
  logic [63:0] addrOut, sizeOut, wrAddr, tagAddr;
  logic [LEN_W-1:0] wrLen, wrAckLen;
  logic [7:0] wrFill;
  logic [3:0] tagValue;
  logic wrAck = 1'b0;

  always #2 clk = ~clk;

  tagFillEngine uut (
    .clk(clk), .rstN(rstN), .start(start), .encSelB(encSelB), .finalStep(finalStep),
    .addrIn(addrIn), .sizeIn(sizeIn), .fillByte(fillByte), .stageLimit(stageLimit),
    .busy(busy), .done(done), .addrOut(addrOut), .sizeOut(sizeOut), .fault(fault),
    .alignFault(alignFault), .wrValid(wrValid), .wrAddr(wrAddr), .wrLen(wrLen),
    .wrFill(wrFill), .wrAck(wrAck), .wrAckLen(wrAckLen), .tagValid(tagValid),
    .tagAddr(tagAddr), .tagValue(tagValue)
  );

  int testsRun = 0, testsFailed = 0;

  // responder and recorders
  int nBlocks, nBytes, nTags, tagErr, orderErr, idleErr, shortIdx;
  logic [6:0] shortLen;
  logic [3:0] expTag;
  logic [63:0] nextTagExp, firstAddr;
  logic [7:0] lastFill;
  int blkLens [0:7];

  initial wrAckLen = '0;

  always @(negedge clk) begin
    if (!busy && (wrValid || tagValid)) idleErr++;
    if (wrValid && !wrAck) begin
      wrAck = 1'b1;
      if (nBlocks == 0) firstAddr = wrAddr;
      lastFill = wrFill;
      if (nBlocks < 8) blkLens[nBlocks] = int'(wrLen);
      if (nBlocks == shortIdx) wrAckLen = shortLen;
      else wrAckLen = wrLen;
      nBytes += int'(wrAckLen);
      nextTagExp = wrAddr + 64'(wrLen) - 64'd16;
      nBlocks++;
    end else begin
      wrAck = 1'b0;
    end
    if (tagValid) begin
      nTags++;
      if (tagAddr !== nextTagExp) orderErr++;
      if (tagValue !== expTag) tagErr++;
      nextTagExp = nextTagExp - 64'd16;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [63:0] resAddr, resSize;
  logic resFault, resAlign;

  task automatic runFill(input logic b, input logic fin, input logic [63:0] a,
                         input logic [63:0] s, input logic [63:0] lim,
                         input logic [7:0] fb, input logic [3:0] et,
                         input int shIdx, input logic [6:0] shLen, input logic poke);
    int cyc;
    nBlocks = 0; nBytes = 0; nTags = 0; tagErr = 0; orderErr = 0; idleErr = 0;
    shortIdx = shIdx; shortLen = shLen; expTag = et; firstAddr = '0; lastFill = '0;
    for (int i = 0; i < 8; i++) blkLens[i] = 0;
    @(negedge clk);
    encSelB = b; finalStep = fin; addrIn = a; sizeIn = s; stageLimit = lim; fillByte = fb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", busy, 1'b1);
    if (poke) begin
      @(negedge clk);
      addrIn = 64'h1234_5678_9ABC_DEF0; sizeIn = 64'h10; encSelB = ~b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) chk("R10 done timeout", 1'b0, 1'b1);
    resAddr = addrOut; resSize = sizeOut; resFault = fault; resAlign = alignFault;
    @(negedge clk);
    chk("R10 done one cycle", done, 1'b0);
    chk("R10 idle after done", busy, 1'b0);
    chk("R10 no idle writes", 64'(idleErr), 0);
    chk("R3 tag order", 64'(orderErr), 0);
    chk("R2 tag value", 64'(tagErr), 0);
  endtask

  task automatic testReset;
    chk("R10 reset busy", busy, 1'b0);
    chk("R10 reset done", done, 1'b0);
    chk("R10 reset wrValid", wrValid, 1'b0);
    chk("R10 reset tagValid", tagValid, 1'b0);
  endtask

  task automatic testOptB;
    runFill(1'b1, 1'b0, 64'h0A00_0000_0000_1000, 64'h100, 64'h60, 8'hC3, 4'hA, -1, 7'd0, 1'b0);
    chk("R6 bytes", 64'(nBytes), 96);
    chk("R1 blocks", 64'(nBlocks), 2);
    chk("R1 first len", 64'(blkLens[0]), 64);
    chk("R1 clipped len", 64'(blkLens[1]), 32);
    chk("R1 fill byte", 64'(lastFill), 64'hC3);
    chk("R2 tag count", 64'(nTags), 6);
    chk("R4 addr", resAddr, 64'h0A00_0000_0000_1060);
    chk("R4 size", resSize, 64'hA0);
    chk("R4 fault", 64'(resFault), 0);
  endtask

  task automatic testOptA;
    runFill(1'b0, 1'b0, 64'h0500_0000_0000_2100, -64'd160, 64'h1000, 8'h5A, 4'h5, -1, 7'd0, 1'b0);
    chk("R5 first block addr", firstAddr, 64'h0500_0000_0000_2060);
    chk("R5 blocks", 64'(nBlocks), 3);
    chk("R2 tag count", 64'(nTags), 10);
    chk("R5 addr", resAddr, 64'h0500_0000_0000_2100);
    chk("R5 size", resSize, 64'h0);
    runFill(1'b0, 1'b0, 64'h0500_0000_0000_3000, -64'd128, 64'h30, 8'h11, 4'h5, -1, 7'd0, 1'b0);
    chk("R6 optA bytes", 64'(nBytes), 48);
    chk("R5 partial size", resSize, -64'd80);
    chk("R5 addr unchanged", resAddr, 64'h0500_0000_0000_3000);
    runFill(1'b0, 1'b0, 64'h0500_0000_0000_3000, 64'd64, 64'h100, 8'h11, 4'h5, -1, 7'd0, 1'b0);
    chk("R5 positive size no fill", 64'(nBlocks), 0);
  endtask

  task automatic testFinal;
    runFill(1'b1, 1'b1, 64'h0300_0000_0000_0400, 64'h50, 64'h10, 8'h77, 4'h3, -1, 7'd0, 1'b0);
    chk("R7 bytes", 64'(nBytes), 80);
    chk("R7 size zero", resSize, 64'h0);
    chk("R7 addr", resAddr, 64'h0300_0000_0000_0450);
  endtask

  task automatic testRound;
    runFill(1'b1, 1'b0, 64'h0200_0000_0000_0000, 64'h100, 64'h25, 8'h01, 4'h2, -1, 7'd0, 1'b0);
    chk("R6 rounded bytes", 64'(nBytes), 32);
    chk("R6 size", resSize, 64'hE0);
    runFill(1'b1, 1'b0, 64'h0200_0000_0000_0000, 64'h100, 64'h0F, 8'h01, 4'h2, -1, 7'd0, 1'b0);
    chk("R11 small budget no writes", 64'(nBlocks), 0);
    chk("R11 no fault", 64'(resFault), 0);
  endtask

  task automatic testAlign;
    runFill(1'b1, 1'b0, 64'h0100_0000_0000_1000, 64'h48, 64'h100, 8'h22, 4'h1, -1, 7'd0, 1'b0);
    chk("R9 size misalign fault", {62'b0, resFault, resAlign}, 2'b11);
    chk("R9 no writes", 64'(nBlocks), 0);
    chk("R9 size unchanged", resSize, 64'h48);
    runFill(1'b1, 1'b0, 64'h0100_0000_0000_1008, 64'h40, 64'h100, 8'h22, 4'h1, -1, 7'd0, 1'b0);
    chk("R9 addr misalign fault", 64'(resAlign), 1);
    chk("R9 addr unchanged", resAddr, 64'h0100_0000_0000_1008);
    runFill(1'b1, 1'b0, 64'h0100_0000_0000_1008, 64'h0, 64'h100, 8'h22, 4'h1, -1, 7'd0, 1'b0);
    chk("R11 zero size no fault", 64'(resFault), 0);
    chk("R11 zero size no writes", 64'(nBlocks), 0);
  endtask

  task automatic testShort;
    runFill(1'b1, 1'b1, 64'h0F00_0000_0000_0000, 64'h80, 64'h1000, 8'h99, 4'hF, 1, 7'd40, 1'b0);
    chk("R8 fault", {62'b0, resFault, resAlign}, 2'b10);
    chk("R8 blocks", 64'(nBlocks), 2);
    chk("R8 tags first block only", 64'(nTags), 4);
    chk("R8 addr", resAddr, 64'h0F00_0000_0000_0040);
    chk("R8 size not zeroed", resSize, 64'h40);
  endtask

  task automatic testPoke;
    runFill(1'b1, 1'b0, 64'h0600_0000_0000_0000, 64'h80, 64'h80, 8'h3C, 4'h6, -1, 7'd0, 1'b1);
    chk("R10 start ignored addr", resAddr, 64'h0600_0000_0000_0080);
    chk("R10 start ignored size", resSize, 64'h0);
    chk("R10 start ignored fill", 64'(lastFill), 64'h3C);
  endtask

  initial begin
    #(200000 * 4);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testOptB();
    testOptA();
    testFinal();
    testRound();
    testAlign();
    testShort();
    testPoke();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule